// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control engine of a single DMA channel. It produces the source and destination word addresses, moves words in atomic blocks of a power-of-two size, and waits a prescaled interval between blocks. It counts words against a per-trigger amount and, in the triggered one-shot mode, against a total amount. A separate datapath performs the actual bus reads and writes. It uses `rd_addr`, `wr_addr` and `fill_sel` on every cycle in which `word_stb` is high.

Software programs the configuration inputs and raises `cfg_enable` to arm the channel. Three modes are available. In immediate mode one burst starts at arm time. In repeating mode one burst runs per start event, indefinitely. In one-shot triggered mode one burst runs per start event until the total is reached. A source mode of "no read" substitutes a constant fill word for the source data. The channel asks for the bus once per block. Once granted, it holds the bus until every word of that block has moved.

Top module: `dma_xfer_seq`

## Requirements
- R1: During and straight after reset, `bus_req`, `word_stb`, `busy` and `irq` are all low.
- R2: A rising edge of `cfg_enable` while idle arms the channel: `busy` is high from the next cycle, and both working addresses start from `cfg_src_base` and `cfg_dst_base`. Dropping `cfg_enable` makes `busy` and `bus_req` low one cycle later, with no `irq`.
- R3: Each side steps once per word by its mode: 0 adds 4, 1 subtracts 4, 2 holds. The addresses shown with a `word_stb` are the ones used for that word.
- R4: Source mode 3 means no source read. `fill_sel` is high with every word strobe, and `rd_addr` does not move. Under source modes 0 to 2, `fill_sel` stays low.
- R5: Words move in blocks of 2^`cfg_blk_log2` strobes on consecutive cycles, and the last block of a burst may be shorter. `bus_req` stays high until `bus_grant` is seen and throughout the block. `word_stb` is never high without `bus_req`.
- R6: Between two blocks of one burst, `bus_req` is low for exactly `cfg_interval` × 4^`cfg_prescale` cycles, where prescale 0..3 divides the clock by 1, 4, 16 or 64. An interval of 0 leaves no low cycle.
- R7: With `cfg_immediate` set, arming alone moves `cfg_burst_words` words and then drops `busy`. Both `cfg_total_words` and `cfg_repeat` are ignored.
- R8: With only `cfg_repeat` set, each `start_evt` moves `cfg_burst_words` words, `cfg_total_words` is ignored, and `busy` stays high.
- R9: With neither mode set, each `start_evt` moves `cfg_burst_words` words, or fewer if the total runs out first. `busy` drops after the word that completes `cfg_total_words`.
- R10: With a side's reload flag set, that side's address restarts from its base at every triggered burst. With the flag clear, the address continues from where the previous burst stopped.
- R11: When `cfg_irq_en` is set, `irq` is a one-cycle pulse in the cycle after the last word of each repeating burst, of the immediate burst, or of the one-shot total. It does not pulse at any other time.
- R12: A `start_evt` that arrives while a burst is running, including in the cycle of its final word, is dropped and starts no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_enable | input | 1 | Channel enable; rising edge arms, low aborts |
| cfg_immediate | input | 1 | Immediate mode select |
| cfg_repeat | input | 1 | Repeating mode select |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_src_base | input | 32 | Programmed source address (word aligned) |
| cfg_dst_base | input | 32 | Programmed destination address (word aligned) |
| cfg_src_mode | input | 2 | Source step: 0 inc, 1 dec, 2 hold, 3 fill |
| cfg_dst_mode | input | 2 | Destination step: 0 inc, 1 dec, 2 hold |
| cfg_src_reload | input | 1 | Restore source address per triggered burst |
| cfg_dst_reload | input | 1 | Restore destination address per triggered burst |
| cfg_blk_log2 | input | 4 | Block size exponent |
| cfg_interval | input | 16 | Inter-block interval in prescaled ticks |
| cfg_prescale | input | 2 | Interval tick divider select |
| cfg_burst_words | input | 24 | Words per trigger (nonzero) |
| cfg_total_words | input | 28 | Total words in one-shot mode (nonzero) |
| start_evt | input | 1 | Start event strobe |
| bus_grant | input | 1 | Arbiter grant |
| bus_req | output | 1 | Bus request, held across a block |
| rd_addr | output | 32 | Current source word address |
| wr_addr | output | 32 | Current destination word address |
| fill_sel | output | 1 | Write the fill constant instead of read data |
| word_stb | output | 1 | One word moves this cycle |
| busy | output | 1 | Channel armed |
| irq | output | 1 | Completion interrupt pulse |

## Verification
A burst's final word and a new start event can share one clock cycle. The channel must complete the burst and drop the event, not start another burst. The bench raises `start_evt` on the exact cycle in which it observes the final `word_stb` of a burst. It then watches several cycles for stray strobes and checks that `busy` still matches the mode. Randomized grant gaps, block sizes, intervals and prescalers also put the block-end decision, which chooses between the interval and an immediate re-request, into the same cycle as burst completion. The gap lengths and the per-word addresses are compared against values computed from the configuration.

// File: rtl/dma_seq_pkg.sv
// Shared types for the DMA channel sequencer.
// Assumes byte addressing with a fixed 32-bit word.
package dma_seq_pkg;

    localparam int unsigned WORD_BYTES = 4;

    typedef enum logic [1:0] {
        STEP_INC  = 2'd0,
        STEP_DEC  = 2'd1,
        STEP_HOLD = 2'd2,
        STEP_NONE = 2'd3
    } step_mode_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_WAIT = 3'd1,
        S_GAP  = 3'd2,
        S_REQ  = 3'd3,
        S_XFER = 3'd4
    } seq_state_e;

endpackage

// File: rtl/dma_seq_addr.sv
// Working address register for one side of the channel.
// Loads the base on arm, optionally restores it at each triggered burst,
// and steps by one word per transferred word according to the step mode.
// Assumes load, restart and step are never requested in the same cycle
// except load with restart, where the base wins either way.
module dma_seq_addr
    import dma_seq_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base,
    input  logic [1:0]    mode,
    input  logic          load,
    input  logic          reload,
    input  logic          restart,
    input  logic          step,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] STRIDE = AW'(WORD_BYTES);

    logic [AW-1:0] addr_q;

    // Address register: base on arm or reload, otherwise word stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load || (restart && reload)) begin
            addr_q <= base;
        end else if (step) begin
            case (step_mode_e'(mode))
                STEP_INC: addr_q <= addr_q + STRIDE;
                STEP_DEC: addr_q <= addr_q - STRIDE;
                default:  addr_q <= addr_q;
            endcase
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/dma_seq_pacer.sv
// Inter-block interval timer with a power-of-four prescaler.
// On start it captures the interval; while run is high it counts prescaled
// ticks and raises expire in the last cycle of interval * 4^prescale cycles.
// Assumes start is only issued with a nonzero interval.
module dma_seq_pacer #(
    parameter int unsigned IVL_W = 16,
    parameter int unsigned PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [IVL_W-1:0] interval,
    input  logic [PRE_W-1:0] prescale,
    output logic             expire
);
    localparam int unsigned DIV_W = 2 * ((1 << PRE_W) - 1);

    logic [IVL_W-1:0] cnt_q;
    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] div_m1;
    logic             tick;

    // Terminal prescaler value: 4^prescale - 1 as a run of ones.
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            div_m1[i] = (i < 2 * int'(prescale));
        end
    end

    assign tick   = run && (pre_q == div_m1);
    assign expire = run && ((tick && cnt_q == IVL_W'(1)) || cnt_q == '0);

    // Prescaler and interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (start) begin
            cnt_q <= interval;
            pre_q <= '0;
        end else if (run) begin
            pre_q <= tick ? '0 : pre_q + DIV_W'(1);
            if (tick && cnt_q != '0) begin
                cnt_q <= cnt_q - IVL_W'(1);
            end
        end
    end

endmodule

// File: rtl/dma_seq_words.sv
// Word accounting: words left in the block, in the burst and in the total.
// The block count is loaded at each grant as the smallest of the block size,
// the burst remainder and (when tracked) the total remainder.
// Assumes burst and total amounts are nonzero.
module dma_seq_words #(
    parameter int unsigned BURST_W  = 24,
    parameter int unsigned TOTAL_W  = 28,
    parameter int unsigned BLKLOG_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm,
    input  logic                burst_load,
    input  logic                blk_load,
    input  logic                step,
    input  logic                track_total,
    input  logic [BURST_W-1:0]  burst_words,
    input  logic [TOTAL_W-1:0]  total_words,
    input  logic [BLKLOG_W-1:0] blk_log2,
    output logic                blk_last,
    output logic                burst_last,
    output logic                total_last
);
    localparam int unsigned CW = (TOTAL_W > BURST_W) ? TOTAL_W : BURST_W;

    logic [BURST_W-1:0] burst_left_q;
    logic [BURST_W-1:0] blk_left_q;
    logic [TOTAL_W-1:0] total_left_q;
    logic [CW-1:0]      blk_size;
    logic [CW-1:0]      blk_fit;

    // Size of the next block after clipping to what remains.
    always_comb begin
        blk_size = CW'(1) << blk_log2;
        blk_fit  = blk_size;
        if (CW'(burst_left_q) < blk_fit) blk_fit = CW'(burst_left_q);
        if (track_total && CW'(total_left_q) < blk_fit) blk_fit = CW'(total_left_q);
    end

    // Burst remainder counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          burst_left_q <= '0;
        else if (burst_load) burst_left_q <= burst_words;
        else if (step)       burst_left_q <= burst_left_q - BURST_W'(1);
    end

    // Block remainder counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        blk_left_q <= '0;
        else if (blk_load) blk_left_q <= BURST_W'(blk_fit);
        else if (step)     blk_left_q <= blk_left_q - BURST_W'(1);
    end

    // Total remainder counter, only decremented in one-shot mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                   total_left_q <= '0;
        else if (arm)                 total_left_q <= total_words;
        else if (step && track_total) total_left_q <= total_left_q - TOTAL_W'(1);
    end

    assign blk_last   = (blk_left_q == BURST_W'(1));
    assign burst_last = (burst_left_q == BURST_W'(1));
    assign total_last = track_total && (total_left_q == TOTAL_W'(1));

endmodule

// File: rtl/dma_xfer_seq.sv
// DMA channel transfer sequencer (top).
// Arms on a rising enable, runs bursts immediately or per start event,
// requests the bus per block, strobes one word per cycle once granted,
// paces blocks with the interval timer and raises a completion interrupt.
// Assumes configuration is stable while armed, except enable.
module dma_xfer_seq
    import dma_seq_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned BURST_W  = 24,
    parameter int unsigned TOTAL_W  = 28,
    parameter int unsigned IVL_W    = 16,
    parameter int unsigned PRE_W    = 2,
    parameter int unsigned BLKLOG_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_enable,
    input  logic                cfg_immediate,
    input  logic                cfg_repeat,
    input  logic                cfg_irq_en,
    input  logic [AW-1:0]       cfg_src_base,
    input  logic [AW-1:0]       cfg_dst_base,
    input  logic [1:0]          cfg_src_mode,
    input  logic [1:0]          cfg_dst_mode,
    input  logic                cfg_src_reload,
    input  logic                cfg_dst_reload,
    input  logic [BLKLOG_W-1:0] cfg_blk_log2,
    input  logic [IVL_W-1:0]    cfg_interval,
    input  logic [PRE_W-1:0]    cfg_prescale,
    input  logic [BURST_W-1:0]  cfg_burst_words,
    input  logic [TOTAL_W-1:0]  cfg_total_words,
    input  logic                start_evt,
    input  logic                bus_grant,
    output logic                bus_req,
    output logic [AW-1:0]       rd_addr,
    output logic [AW-1:0]       wr_addr,
    output logic                fill_sel,
    output logic                word_stb,
    output logic                busy,
    output logic                irq
);
    seq_state_e state_q, state_d;
    logic en_q, imm_q, rep_q, irq_q;
    logic arm, trig, burst_go, grant_take, in_xfer;
    logic blk_last, burst_last, total_last, end_burst;
    logic gap_start, gap_expire, irq_fire, finish;

    assign arm        = (state_q == S_IDLE) && cfg_enable && !en_q;
    assign trig       = (state_q == S_WAIT) && cfg_enable && start_evt;
    assign burst_go   = trig || (arm && cfg_immediate);
    assign grant_take = (state_q == S_REQ) && cfg_enable && bus_grant;
    assign in_xfer    = (state_q == S_XFER);
    assign end_burst  = in_xfer && (burst_last || total_last);
    assign finish     = imm_q || (!rep_q && total_last);
    assign gap_start  = in_xfer && cfg_enable && blk_last && !end_burst
                        && (cfg_interval != '0);
    assign irq_fire   = end_burst && cfg_enable && cfg_irq_en
                        && (imm_q || rep_q || total_last);

    // Next-state logic for the channel sequencer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE: if (arm) state_d = cfg_immediate ? S_REQ : S_WAIT;
            S_WAIT: if (trig) state_d = S_REQ;
            S_GAP:  if (gap_expire) state_d = S_REQ;
            S_REQ:  if (grant_take) state_d = S_XFER;
            S_XFER: begin
                if (end_burst)     state_d = finish ? S_IDLE : S_WAIT;
                else if (blk_last) state_d = (cfg_interval != '0) ? S_GAP : S_REQ;
            end
            default: state_d = S_IDLE;
        endcase
        if (state_q != S_IDLE && !cfg_enable) state_d = S_IDLE;
    end

    // State, enable edge history, latched mode and interrupt register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            en_q    <= 1'b0;
            imm_q   <= 1'b0;
            rep_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= cfg_enable;
            irq_q   <= irq_fire;
            if (arm) begin
                imm_q <= cfg_immediate;
                rep_q <= cfg_repeat && !cfg_immediate;
            end
        end
    end

    dma_seq_addr #(.AW(AW)) u_src_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .base    (cfg_src_base),
        .mode    (cfg_src_mode),
        .load    (arm),
        .reload  (cfg_src_reload),
        .restart (trig),
        .step    (in_xfer),
        .addr    (rd_addr)
    );

    dma_seq_addr #(.AW(AW)) u_dst_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .base    (cfg_dst_base),
        .mode    (cfg_dst_mode),
        .load    (arm),
        .reload  (cfg_dst_reload),
        .restart (trig),
        .step    (in_xfer),
        .addr    (wr_addr)
    );

    dma_seq_pacer #(.IVL_W(IVL_W), .PRE_W(PRE_W)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (gap_start),
        .run      (state_q == S_GAP),
        .interval (cfg_interval),
        .prescale (cfg_prescale),
        .expire   (gap_expire)
    );

    dma_seq_words #(.BURST_W(BURST_W), .TOTAL_W(TOTAL_W), .BLKLOG_W(BLKLOG_W)) u_words (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .burst_load  (burst_go),
        .blk_load    (grant_take),
        .step        (in_xfer),
        .track_total (!imm_q && !rep_q),
        .burst_words (cfg_burst_words),
        .total_words (cfg_total_words),
        .blk_log2    (cfg_blk_log2),
        .blk_last    (blk_last),
        .burst_last  (burst_last),
        .total_last  (total_last)
    );

    assign bus_req  = (state_q == S_REQ) || in_xfer;
    assign word_stb = in_xfer;
    assign fill_sel = in_xfer && (step_mode_e'(cfg_src_mode) == STEP_NONE);
    assign busy     = (state_q != S_IDLE);
    assign irq      = irq_q;

endmodule

// File: rtl/dma_xfer_seq_chk.sv
// Protocol checker for the DMA channel sequencer, bound to the top.
// Observes ports only.
module dma_xfer_seq_chk
    import dma_seq_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_enable,
    input logic          cfg_irq_en,
    input logic [1:0]    cfg_dst_mode,
    input logic          bus_grant,
    input logic          bus_req,
    input logic          word_stb,
    input logic          fill_sel,
    input logic [AW-1:0] rd_addr,
    input logic [AW-1:0] wr_addr,
    input logic          busy,
    input logic          irq
);
    // R5
    strobe_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> bus_req);

    // R5
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !word_stb && !bus_grant && cfg_enable) |=> bus_req);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !word_stb));

    // R2
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg_enable) |=> !busy);

    // R11
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R11
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cfg_irq_en));

    // R3
    dst_inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && $past(word_stb) && cfg_dst_mode == 2'd0 && $past(cfg_dst_mode) == 2'd0)
        |-> (wr_addr == $past(wr_addr) + AW'(WORD_BYTES)));

    // R4
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && fill_sel && $past(word_stb) && $past(fill_sel)) |-> $stable(rd_addr));

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_enable   (cfg_enable),
    .cfg_irq_en   (cfg_irq_en),
    .cfg_dst_mode (cfg_dst_mode),
    .bus_grant    (bus_grant),
    .bus_req      (bus_req),
    .word_stb     (word_stb),
    .fill_sel     (fill_sel),
    .rd_addr      (rd_addr),
    .wr_addr      (wr_addr),
    .busy         (busy),
    .irq          (irq)
);

// File: tb/dma_xfer_seq_bench.sv
`timescale 1ns/1ps
module dma_xfer_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_enable, cfg_immediate, cfg_repeat, cfg_irq_en;
    logic [31:0] cfg_src_base, cfg_dst_base;
    logic [1:0]  cfg_src_mode, cfg_dst_mode;
    logic        cfg_src_reload, cfg_dst_reload;
    logic [3:0]  cfg_blk_log2;
    logic [15:0] cfg_interval;
    logic [1:0]  cfg_prescale;
    logic [23:0] cfg_burst_words;
    logic [27:0] cfg_total_words;
    logic        start_evt, bus_grant;
    logic        bus_req, fill_sel, word_stb, busy, irq;
    logic [31:0] rd_addr, wr_addr;

    int nchk = 0;
    int nfail = 0;
    logic [31:0] exp_rd, exp_wr;

    always #10 clk = ~clk;

    dma_xfer_seq u_dma_xfer_seq (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_immediate(cfg_immediate),
        .cfg_repeat(cfg_repeat), .cfg_irq_en(cfg_irq_en), .cfg_src_base(cfg_src_base),
        .cfg_dst_base(cfg_dst_base), .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
        .cfg_src_reload(cfg_src_reload), .cfg_dst_reload(cfg_dst_reload),
        .cfg_blk_log2(cfg_blk_log2), .cfg_interval(cfg_interval), .cfg_prescale(cfg_prescale),
        .cfg_burst_words(cfg_burst_words), .cfg_total_words(cfg_total_words),
        .start_evt(start_evt), .bus_grant(bus_grant), .bus_req(bus_req), .rd_addr(rd_addr),
        .wr_addr(wr_addr), .fill_sel(fill_sel), .word_stb(word_stb), .busy(busy), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] a, input logic [1:0] m);
        case (m)
            2'd0:    return a + 32'd4;
            2'd1:    return a - 32'd4;
            default: return a;
        endcase
    endfunction

    // Pulse a start event for one clock.
    task automatic trigger();
        start_evt = 1'b1;
        @(negedge clk);
        start_evt = 1'b0;
    endtask

    // Collect one burst of n words, checking addresses, block grouping and gaps.
    task automatic take_burst(input int n, input bit exp_busy, input bit exp_irq,
                              input bit poke, input string mreq);
        int blk = 1 << cfg_blk_log2;
        int gap_exp = int'(cfg_interval) * (1 << (2 * int'(cfg_prescale)));
        int seen = 0, low = 0, lastc = 0, cyc = 0, stray = 0;
        string lr, lw;
        while (seen < n && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            bus_grant = ($urandom % 3) != 0;
            if (word_stb) begin
                if (seen > 0) begin
                    if (seen % blk == 0) chk(low == gap_exp, "R6", "gap cycles", low, gap_exp);
                    else chk(cyc - lastc == 1, "R5", "block contiguity", cyc - lastc, 1);
                end
                lr = (seen == 0 && cfg_src_reload) ? "R10" : ((cfg_src_mode == 2'd3) ? "R4" : "R3");
                lw = (seen == 0 && cfg_dst_reload) ? "R10" : "R3";
                chk(rd_addr == exp_rd, lr, "rd_addr", rd_addr, exp_rd);
                chk(wr_addr == exp_wr, lw, "wr_addr", wr_addr, exp_wr);
                chk(fill_sel == (cfg_src_mode == 2'd3), "R4", "fill_sel", fill_sel,
                    cfg_src_mode == 2'd3);
                exp_rd = nxt(exp_rd, cfg_src_mode);
                exp_wr = nxt(exp_wr, cfg_dst_mode);
                seen++;
                low = 0;
                lastc = cyc;
                if (seen == n && poke) start_evt = 1'b1;
            end else if (!bus_req) begin
                low++;
            end
        end
        chk(seen == n, mreq, "words in burst", seen, n);
        @(negedge clk);
        start_evt = 1'b0;
        bus_grant = 1'b1;
        chk(word_stb == 1'b0, "R5", "no extra word", word_stb, 0);
        chk(irq == exp_irq, "R11", "irq after burst", irq, exp_irq);
        chk(busy == exp_busy, mreq, "busy after burst", busy, exp_busy);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (word_stb) stray++;
            if (irq) stray++;
        end
        chk(stray == 0, "R12", "quiet after burst", stray, 0);
        chk(busy == exp_busy, "R12", "busy held", busy, exp_busy);
    endtask

    // One configured scenario: 0 immediate, 1 repeating, 2 one-shot.
    task automatic run_case(input int mode, input int ntrig, input bit poke);
        int tl;
        int n;
        exp_rd = cfg_src_base;
        exp_wr = cfg_dst_base;
        bus_grant = 1'b1;
        cfg_enable = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R2", "busy after arm", busy, 1);
        if (mode == 0) begin
            take_burst(int'(cfg_burst_words), 1'b0, cfg_irq_en, poke, "R7");
        end else if (mode == 1) begin
            for (int t = 0; t < ntrig; t++) begin
                if (cfg_src_reload) exp_rd = cfg_src_base;
                if (cfg_dst_reload) exp_wr = cfg_dst_base;
                trigger();
                take_burst(int'(cfg_burst_words), 1'b1, cfg_irq_en, poke, "R8");
            end
        end else begin
            tl = int'(cfg_total_words);
            while (tl > 0) begin
                n = (int'(cfg_burst_words) < tl) ? int'(cfg_burst_words) : tl;
                tl -= n;
                if (cfg_src_reload) exp_rd = cfg_src_base;
                if (cfg_dst_reload) exp_wr = cfg_dst_base;
                trigger();
                take_burst(n, tl > 0, cfg_irq_en && tl == 0, poke, "R9");
            end
        end
        cfg_enable = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R2", "busy after disable", busy, 0);
        chk(irq == 1'b0, "R11", "no irq on disable", irq, 0);
    endtask

    task automatic set_cfg(input bit imm, input bit rep, input int blog, input int bw,
                           input int tw, input int ivl, input int pre,
                           input int sm, input int dm, input bit sr, input bit dr, input bit ie);
        cfg_immediate = imm; cfg_repeat = rep; cfg_blk_log2 = 4'(blog);
        cfg_burst_words = 24'(bw); cfg_total_words = 28'(tw);
        cfg_interval = 16'(ivl); cfg_prescale = 2'(pre);
        cfg_src_mode = 2'(sm); cfg_dst_mode = 2'(dm);
        cfg_src_reload = sr; cfg_dst_reload = dr; cfg_irq_en = ie;
        cfg_src_base = {$urandom} & 32'hFFFF_FFFC;
        cfg_dst_base = {$urandom} & 32'hFFFF_FFFC;
    endtask

    initial begin
        int mode, cnt;
        void'($urandom(32'd20250417));
        rst_n = 1'b0; cfg_enable = 1'b0; start_evt = 1'b0; bus_grant = 1'b1;
        set_cfg(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk(!bus_req && !word_stb && !busy && !irq, "R1", "outputs in reset",
            {bus_req, word_stb, busy, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !word_stb && !busy && !irq, "R1", "outputs after reset",
            {bus_req, word_stb, busy, irq}, 0);

        // R7: immediate with repeat also set and a tiny total, uneven last block.
        set_cfg(1, 1, 2, 10, 1, 2, 1, 0, 1, 0, 0, 1);
        run_case(0, 0, 1'b1);
        // R8, R10: repeating, source reloads, destination continues.
        set_cfg(0, 1, 1, 3, 2, 0, 0, 0, 0, 1, 0, 1);
        run_case(1, 3, 1'b1);
        // R9, R4: one-shot with fill source, total not a multiple of burst.
        set_cfg(0, 0, 3, 4, 10, 1, 2, 3, 1, 0, 1, 1);
        run_case(2, 0, 1'b1);
        // R6: largest prescale, R11 with interrupts disabled.
        set_cfg(1, 0, 0, 3, 5, 1, 3, 1, 2, 0, 0, 0);
        run_case(0, 0, 1'b0);

        // R2: abort in the middle of a burst.
        set_cfg(1, 0, 3, 20, 1, 0, 0, 0, 0, 0, 0, 1);
        cfg_enable = 1'b1;
        cnt = 0;
        for (int i = 0; i < 50 && cnt < 3; i++) begin
            @(negedge clk);
            if (word_stb) cnt++;
        end
        cfg_enable = 1'b0;
        @(negedge clk);
        chk(!busy && !bus_req, "R2", "abort drops busy/req", {busy, bus_req}, 0);
        cnt = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (word_stb || irq) cnt++;
        end
        chk(cnt == 0, "R2", "no words or irq after abort", cnt, 0);

        // Random mix of modes, sizes, intervals and address modes.
        for (int c = 0; c < 24; c++) begin
            mode = $urandom % 3;
            set_cfg(mode == 0, mode == 1 || (mode == 0 && ($urandom % 2) == 1),
                    $urandom % 4, 1 + $urandom % 12, 1 + $urandom % 16,
                    $urandom % 4, $urandom % 3, $urandom % 4, $urandom % 3,
                    $urandom % 2, $urandom % 2, $urandom % 2);
            run_case(mode, 2, $urandom % 2);
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule